// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps each incoming transaction address onto a target identifier. Software programs a fixed set of address windows through a simple word-addressed register port. Each window has four registers: a control word with an enable bit and a target field, a security word, a lower bound and an inclusive upper bound. A single global register names the default target. The default target receives every address that falls inside no enabled window.

Bounds have 1 MiB granularity. Each bound register holds a physical address shifted right by 16, with its low nibble always zero. A window therefore covers page `lo[31:4]` through page `hi[31:4]`, both inclusive, where a page is address bits [39:20]. The decode port takes one 40-bit address per cycle, along with a write flag and a non-secure flag. One cycle later it reports the target, whether a window was hit, and whether the access broke a window's security setting. Software can read back every register, so it can save the whole map and restore it later.

Top module: `addr_dec_top`

## Requirements
- R1: After reset, every window is disabled, and every window register and the global register read as zero. `res_valid` is low.
- R2: Register word address `4*w + s` selects window `w`. Slot `s` selects: 0 = control, 1 = security, 2 = lower bound, 3 = upper bound. Word address `4*NUM_WIN` is the global register. Stored bits read back as written: control bits [7:4] (target) and bit 0 (enable), security bits [1:0], bound bits [31:4], and global bits [3:0] (default target). All other bits read as zero. Writes to unused addresses change nothing, and reads from unused addresses return zero.
- R3: A window whose control bit 0 is clear never matches any address.
- R4: An enabled window matches when `lo[31:4] <= {8'b0, addr[39:20]} <= hi[31:4]`, with both ends included. A hit returns that window's control target and `res_hit=1`. Bound bits [31:24] take part in the comparison, so setting them can place a window beyond the 40-bit space.
- R5: When several enabled windows match, the window with the lowest number supplies the result.
- R6: An address that matches no enabled window returns the global default target with `res_hit=0` and `res_secviol=0`.
- R7: `res_valid` equals `dec_valid` delayed by one clock. The result reflects the register contents as they stood at the clock edge that captured the request.
- R8: Security bit 0 is write-secure and bit 1 is read-secure. A write to the security register with bit 0 set stores bit 1 as zero.
- R9: A non-secure access (`dec_nonsecure=1`) that selects a window raises `res_secviol=1` in two cases: a write to a window with write-secure set, or a read from a window with read-secure set. It then returns `res_hit=0` and target 0. A secure access never raises `res_secviol`.
- R10: Clearing the enable bit leaves that window's target and bounds intact. Setting the enable bit again restores the same match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W (6) | Register word address |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Combinational readback of `reg_addr` |
| dec_valid | input | 1 | Decode request valid |
| dec_addr | input | ADDR_W (40) | Transaction address |
| dec_write | input | 1 | 1 = write, 0 = read |
| dec_nonsecure | input | 1 | Transaction is non-secure |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_target | output | TID_W (4) | Selected target ID |
| res_hit | output | 1 | An enabled window supplied the target |
| res_secviol | output | 1 | Security violation flagged |

## Verification
The bench builds the block with its defaults: eight windows, a 40-bit address, 4-bit targets and 32-bit registers. With these values the full register space of 33 words and a few unused words above it can be exercised. Random bounds are drawn from a small page range so that windows overlap often. This brings priority between windows, inclusive end pages, and the neighbouring pages just outside each window within reach of a few hundred random vectors.

// File: rtl/addr_dec_pkg.sv
// Package: register-slot encoding and bit positions shared by the decoder.
// Assumes 32-bit registers with targets in control bits [7:4].
package addr_dec_pkg;
    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_SEC  = 2'd1,
        SLOT_LO   = 2'd2,
        SLOT_HI   = 2'd3
    } slot_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_TID_LSB = 4;
    localparam int SEC_WR_BIT = 0;
    localparam int SEC_RD_BIT = 1;
    localparam int BOUND_LSB = 4;
    localparam int PAGE_SHIFT = 20;
endpackage

// File: rtl/addr_dec_regs.sv
// Module: window and global register file with combinational readback.
// Assumes DATA_W > CTRL_TID_LSB + TID_W and RA_W wide enough for 4*NUM_WIN.
module addr_dec_regs
    import addr_dec_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int DATA_W  = 32,
    parameter int TID_W   = 4,
    parameter int RA_W    = 6,
    localparam int BND_W  = DATA_W - BOUND_LSB
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [RA_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic [NUM_WIN-1:0]            win_en,
    output logic [NUM_WIN-1:0][TID_W-1:0] win_tid,
    output logic [NUM_WIN-1:0]            win_wsec,
    output logic [NUM_WIN-1:0]            win_rsec,
    output logic [NUM_WIN-1:0][BND_W-1:0] win_lo,
    output logic [NUM_WIN-1:0][BND_W-1:0] win_hi,
    output logic [TID_W-1:0]              dflt_tid
);
    localparam logic [RA_W-1:0] GLB_ADDR = RA_W'(NUM_WIN * 4);

    logic [RA_W-3:0] idx;
    slot_e           slot;

    assign idx  = reg_addr[RA_W-1:2];
    assign slot = slot_e'(reg_addr[1:0]);

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            logic sel;
            assign sel = reg_we && (idx == (RA_W-2)'(w));

            // Hold one window's fields; each slot writes only its own field.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    win_en[w]   <= 1'b0;
                    win_tid[w]  <= '0;
                    win_wsec[w] <= 1'b0;
                    win_rsec[w] <= 1'b0;
                    win_lo[w]   <= '0;
                    win_hi[w]   <= '0;
                end else if (sel) begin
                    case (slot)
                        SLOT_CTRL: begin
                            win_en[w]  <= reg_wdata[CTRL_EN_BIT];
                            win_tid[w] <= reg_wdata[CTRL_TID_LSB +: TID_W];
                        end
                        SLOT_SEC: begin
                            win_wsec[w] <= reg_wdata[SEC_WR_BIT];
                            win_rsec[w] <= reg_wdata[SEC_RD_BIT] & ~reg_wdata[SEC_WR_BIT];
                        end
                        SLOT_LO: win_lo[w] <= reg_wdata[DATA_W-1:BOUND_LSB];
                        SLOT_HI: win_hi[w] <= reg_wdata[DATA_W-1:BOUND_LSB];
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

    // Hold the default target used when no window matches.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dflt_tid <= '0;
        else if (reg_we && reg_addr == GLB_ADDR)
            dflt_tid <= reg_wdata[TID_W-1:0];
    end

    // Rebuild the addressed register image for software readback.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == GLB_ADDR) begin
            reg_rdata[TID_W-1:0] = dflt_tid;
        end else begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (idx == (RA_W-2)'(i)) begin
                    case (slot)
                        SLOT_CTRL: begin
                            reg_rdata[CTRL_EN_BIT] = win_en[i];
                            reg_rdata[CTRL_TID_LSB +: TID_W] = win_tid[i];
                        end
                        SLOT_SEC: begin
                            reg_rdata[SEC_WR_BIT] = win_wsec[i];
                            reg_rdata[SEC_RD_BIT] = win_rsec[i];
                        end
                        SLOT_LO: reg_rdata[DATA_W-1:BOUND_LSB] = win_lo[i];
                        SLOT_HI: reg_rdata[DATA_W-1:BOUND_LSB] = win_hi[i];
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/addr_dec_match.sv
// Module: range comparator for one window at 1 MiB page resolution.
// Assumes the page number (ADDR_W-20 bits) fits in the bound field width.
module addr_dec_match #(
    parameter int BND_W  = 28,
    parameter int PAGE_W = 20
) (
    input  logic              en,
    input  logic [BND_W-1:0]  lo,
    input  logic [BND_W-1:0]  hi,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);
    logic [BND_W-1:0] page_ext;

    // Zero-extend the page and test both inclusive bounds.
    always_comb begin
        page_ext = BND_W'(page);
        hit = en && (page_ext >= lo) && (page_ext <= hi);
    end
endmodule

// File: rtl/addr_dec_prio.sv
// Module: fixed-priority picker, lowest index first.
// Assumes NUM_WIN >= 2.
module addr_dec_prio #(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so the lowest set index is assigned last.
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/addr_dec_top.sv
// Module: address window decoder top. It registers one decode result per
// request, one cycle after the request. It assumes requests use the
// register contents at the same edge that captures them.
module addr_dec_top
    import addr_dec_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 40,
    parameter int TID_W   = 4,
    parameter int DATA_W  = 32,
    localparam int RA_W   = $clog2(NUM_WIN * 4 + 1),
    localparam int BND_W  = DATA_W - BOUND_LSB,
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              dec_write,
    input  logic              dec_nonsecure,
    output logic              res_valid,
    output logic [TID_W-1:0]  res_target,
    output logic              res_hit,
    output logic              res_secviol
);
    logic [NUM_WIN-1:0]            win_en;
    logic [NUM_WIN-1:0][TID_W-1:0] win_tid;
    logic [NUM_WIN-1:0]            win_wsec;
    logic [NUM_WIN-1:0]            win_rsec;
    logic [NUM_WIN-1:0][BND_W-1:0] win_lo;
    logic [NUM_WIN-1:0][BND_W-1:0] win_hi;
    logic [TID_W-1:0]              dflt_tid;
    logic [NUM_WIN-1:0]            hits;
    logic                          any_hit;
    logic [IDX_W-1:0]              win_idx;
    logic                          viol;

    addr_dec_regs #(
        .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .TID_W(TID_W), .RA_W(RA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_en(win_en),
        .win_tid(win_tid), .win_wsec(win_wsec), .win_rsec(win_rsec),
        .win_lo(win_lo), .win_hi(win_hi), .dflt_tid(dflt_tid)
    );

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_cmp
            addr_dec_match #(.BND_W(BND_W), .PAGE_W(PAGE_W)) u_match (
                .en(win_en[w]), .lo(win_lo[w]), .hi(win_hi[w]),
                .page(dec_addr[ADDR_W-1:PAGE_SHIFT]), .hit(hits[w])
            );
        end
    endgenerate

    addr_dec_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .hits(hits), .any(any_hit), .idx(win_idx)
    );

    // Flag a non-secure access that breaks the selected window's policy.
    always_comb begin
        viol = any_hit && dec_nonsecure &&
               (dec_write ? win_wsec[win_idx] : win_rsec[win_idx]);
    end

    // Register the decode result for one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_target  <= '0;
            res_hit     <= 1'b0;
            res_secviol <= 1'b0;
        end else begin
            res_valid <= dec_valid;
            if (dec_valid) begin
                res_secviol <= viol;
                res_hit     <= any_hit && !viol;
                res_target  <= viol ? '0 : (any_hit ? win_tid[win_idx] : dflt_tid);
            end
        end
    end
endmodule

// File: rtl/addr_dec_chk.sv
// Module: assertion checker for addr_dec_top, attached by bind below.
// Assumes it sees the top's ports plus the stored default target.
module addr_dec_chk #(
    parameter int TID_W   = 4,
    parameter int DATA_W  = 32,
    parameter int RA_W    = 6,
    parameter int NUM_WIN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [RA_W-1:0]   reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              dec_valid,
    input logic              dec_nonsecure,
    input logic              res_valid,
    input logic [TID_W-1:0]  res_target,
    input logic              res_hit,
    input logic              res_secviol,
    input logic [TID_W-1:0]  dflt_tid
);
    localparam logic [RA_W-1:0] GLB_ADDR = RA_W'(NUM_WIN * 4);

    // R7
    req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> res_valid);

    // R7
    idle_to_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> !res_valid);

    // R9
    viol_not_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_secviol) |-> (!res_hit && res_target == '0));

    // R9
    viol_needs_nonsecure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_nonsecure) |=> !res_secviol);

    // R6
    miss_uses_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit && !res_secviol) |-> (res_target == $past(dflt_tid)));

    // R2
    glb_write_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == GLB_ADDR) |=> (dflt_tid == $past(reg_wdata[TID_W-1:0])));
endmodule

bind addr_dec_top addr_dec_chk #(
    .TID_W(TID_W), .DATA_W(DATA_W), .RA_W(RA_W), .NUM_WIN(NUM_WIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dec_valid(dec_valid), .dec_nonsecure(dec_nonsecure),
    .res_valid(res_valid), .res_target(res_target), .res_hit(res_hit),
    .res_secviol(res_secviol), .dflt_tid(dflt_tid)
);

// File: tb/addr_dec_top_tb.sv
module addr_dec_top_tb;
    localparam int NW = 8;
    localparam int RAW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dec_valid = 1'b0;
    logic [39:0] dec_addr = '0;
    logic        dec_write = 1'b0;
    logic        dec_nonsecure = 1'b0;
    logic        res_valid;
    logic [3:0]  res_target;
    logic        res_hit;
    logic        res_secviol;

    int vectors = 0;
    int errors = 0;

    logic [31:0] m_ctrl [NW];
    logic [31:0] m_sec  [NW];
    logic [31:0] m_lo   [NW];
    logic [31:0] m_hi   [NW];
    logic [31:0] m_glb;

    always #5 clk = ~clk;

    addr_dec_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_valid(dec_valid),
        .dec_addr(dec_addr), .dec_write(dec_write), .dec_nonsecure(dec_nonsecure),
        .res_valid(res_valid), .res_target(res_target), .res_hit(res_hit),
        .res_secviol(res_secviol)
    );

    function automatic logic [31:0] model_read(input logic [5:0] a);
        int w = int'(a[5:2]);
        if (a == 6'(NW * 4)) return m_glb;
        if (w >= NW) return 32'h0;
        case (a[1:0])
            2'd0: return m_ctrl[w];
            2'd1: return m_sec[w];
            2'd2: return m_lo[w];
            default: return m_hi[w];
        endcase
    endfunction

    // Expected decode as {viol, hit, target}.
    function automatic logic [5:0] model_dec(input logic [39:0] a, input logic wr,
                                             input logic ns);
        logic [27:0] pg = {8'h0, a[39:20]};
        for (int w = 0; w < NW; w++) begin
            if (m_ctrl[w][0] && pg >= m_lo[w][31:4] && pg <= m_hi[w][31:4]) begin
                if (ns && (wr ? m_sec[w][0] : m_sec[w][1])) return 6'b10_0000;
                return {2'b01, m_ctrl[w][7:4]};
            end
        end
        return {2'b00, m_glb[3:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        int w = int'(a[5:2]);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 6'(NW * 4)) m_glb = d & 32'hF;
        else if (w < NW) begin
            case (a[1:0])
                2'd0: m_ctrl[w] = d & 32'hF1;
                2'd1: m_sec[w] = d[0] ? 32'h1 : (d & 32'h3);
                2'd2: m_lo[w] = d & 32'hFFFF_FFF0;
                default: m_hi[w] = d & 32'hFFFF_FFF0;
            endcase
        end
    endtask

    task automatic do_read(input string req, input logic [5:0] a);
        reg_addr = a;
        #1;
        check(req, reg_rdata, model_read(a));
    endtask

    task automatic do_dec(input string req, input logic [39:0] a, input logic wr,
                          input logic ns);
        logic [5:0] e;
        dec_valid = 1'b1; dec_addr = a; dec_write = wr; dec_nonsecure = ns;
        e = model_dec(a, wr, ns);
        @(negedge clk);
        dec_valid = 1'b0;
        check(req, {25'h0, res_valid, res_secviol, res_hit, res_target}, {25'h0, 1'b1, e});
    endtask

    function automatic logic [39:0] pg_addr(input int pg, input logic [19:0] off);
        return {20'(pg), off};
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int w = 0; w < NW; w++) begin
            m_ctrl[w] = 0; m_sec[w] = 0; m_lo[w] = 0; m_hi[w] = 0;
        end
        m_glb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 res_valid", {31'h0, res_valid}, 32'h0);
        for (int a = 0; a <= NW * 4; a++) do_read("R1 reset readback", 6'(a));
        do_dec("R1 reset decode miss", 40'h12_3456_7890, 1'b0, 1'b0);

        // R2 field masks and unused addresses
        do_write(6'(NW * 4), 32'hFFFF_FFF5);
        do_read("R2 global mask", 6'(NW * 4));
        do_write(6'd40, 32'hFFFF_FFFF);
        do_read("R2 unused address reads zero", 6'd40);
        do_read("R2 global unchanged by unused write", 6'(NW * 4));
        do_write(6'd0, 32'hFFFF_FF0E);
        do_read("R2 ctrl mask", 6'd0);
        do_write(6'd0, 32'h0);
        do_dec("R6 miss gives default", pg_addr(5, 20'h1), 1'b0, 1'b0);

        // R4 inclusive bounds on window 3
        do_write(6'd14, 32'h0000_010F);
        do_write(6'd15, 32'h0000_01F3);
        do_read("R2 lo low nibble cleared", 6'd14);
        do_write(6'd12, 32'h0000_0091);
        do_dec("R4 first page", pg_addr('h10, 20'h0), 1'b0, 1'b0);
        do_dec("R4 last page inclusive", pg_addr('h1F, 20'hFFFFF), 1'b1, 1'b1);
        do_dec("R6 page above end", pg_addr('h20, 20'h0), 1'b0, 1'b0);
        do_dec("R6 page below base", pg_addr('h0F, 20'hFFFFF), 1'b0, 1'b0);

        // R5 overlap: window 1 covers 0x18..0x30
        do_write(6'd6, 32'h0000_0180);
        do_write(6'd7, 32'h0000_0300);
        do_write(6'd4, 32'h0000_0021);
        do_dec("R5 lower window wins", pg_addr('h18, 20'h5), 1'b0, 1'b0);
        do_dec("R4 window 1 only", pg_addr('h30, 20'h5), 1'b0, 1'b0);

        // R3 / R10 disable then re-enable
        do_write(6'd4, 32'h0000_0020);
        do_dec("R3 disabled window skipped", pg_addr('h18, 20'h5), 1'b0, 1'b0);
        do_read("R10 lo kept", 6'd6);
        do_read("R10 hi kept", 6'd7);
        do_read("R10 target kept", 6'd4);
        do_write(6'd4, 32'h0000_0021);
        do_dec("R10 re-enable restores", pg_addr('h18, 20'h5), 1'b0, 1'b0);

        // R8 security register rule
        do_write(6'd13, 32'h3);
        do_read("R8 write-secure clears read-secure", 6'd13);
        do_write(6'd13, 32'h2);
        do_read("R8 read-secure alone", 6'd13);
        do_dec("R9 ns read blocked", pg_addr('h12, 20'h0), 1'b0, 1'b1);
        do_dec("R9 secure read allowed", pg_addr('h12, 20'h0), 1'b0, 1'b0);
        do_write(6'd13, 32'h1);
        do_dec("R9 ns write blocked", pg_addr('h12, 20'h0), 1'b1, 1'b1);
        do_dec("R9 secure write allowed", pg_addr('h12, 20'h0), 1'b1, 1'b0);
        do_dec("R9 ns read allowed", pg_addr('h12, 20'h0), 1'b0, 1'b1);

        // R4 upper bound bits place window 5 out of reach
        do_write(6'd22, 32'h0100_0400);
        do_write(6'd23, 32'h0100_0FF0);
        do_write(6'd20, 32'h0000_0071);
        do_dec("R4 upper bits exclude", pg_addr('h40, 20'h0), 1'b0, 1'b0);

        // R7 back-to-back then idle
        do_dec("R7 back-to-back a", pg_addr('h11, 20'h0), 1'b0, 1'b0);
        do_dec("R7 back-to-back b", pg_addr('h31, 20'h0), 1'b0, 1'b0);
        @(negedge clk);
        check("R7 idle drops valid", {31'h0, res_valid}, 32'h0);

        // Random mix over a small page range
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            if (op < 3) begin
                int w = $urandom_range(0, NW - 1);
                int s = $urandom_range(0, 4);
                int lp = $urandom_range(0, 63);
                logic [31:0] d;
                case (s)
                    0: d = $urandom;
                    1: d = 32'($urandom_range(0, 3));
                    2: d = {4'h0, 24'(lp), 4'($urandom)};
                    3: d = {4'h0, 24'(lp + $urandom_range(0, 20)), 4'($urandom)};
                    default: d = $urandom;
                endcase
                if (s == 4) do_write(6'(NW * 4), d);
                else do_write(6'(w * 4 + s), d);
            end else if (op < 4) begin
                do_read("R2 random readback", 6'($urandom_range(0, 40)));
            end else begin
                do_dec("R4 random decode", pg_addr($urandom_range(0, 90), 20'($urandom)),
                       1'($urandom), 1'($urandom));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule